// File: doc/BRIEF.md
# Cross trigger channel interface

This block connects a group of local event lines to a small set of shared broadcast channels. Each input trigger can be attached to any subset of the channels. Each channel can in turn drive any subset of the output triggers. A channel that is active locally is sent to a shared channel matrix, but only if the propagation gate for that channel is open. A channel that arrives back from the matrix drives the local output triggers attached to it, in the same way as a local channel.

Software programs the block through a simple synchronous write port and a combinational read port. Besides the attachment masks, it can force channels active, release them or pulse them for one cycle. It can also close per-channel gates, mark output triggers as unsafe so that a filter keeps them low, and turn the whole block on or off. Status words show the live channel and trigger state as one-hot bitmaps. A channel view reports which channels have attachments and which are free.

Top module: `xtrig_chan_if`

## Requirements
- R1: After reset, trig_out and ch_out are 0. CTRL (address 0x00, bit 0 enable, bit 1 filter on) reads 0x2. GATE (0x04) reads 0xF. All attachment masks read 0, so input triggers and matrix channels have no effect.
- R2: The in-attach mask of input trigger i (address 0x10+i, bits 3:0 = channels) connects that trigger to channels. The out-attach mask of channel c (address 0x20+c, bits 7:0 = output triggers) connects that channel to output triggers. While enabled, a high input trigger makes every attached channel active. One clock later, the active channels appear on ch_out and their attached output triggers appear on trig_out. Several sources are ORed.
- R3: A channel that is high on ch_in drives the output triggers attached to it one clock later. It is never copied to ch_out.
- R4: A cleared bit c in GATE keeps ch_out[c] at 0. Local output triggers attached to channel c are still driven.
- R5: Writing 1s to SET (0x01) holds those channels active. Writing 1s to CLR (0x02) releases them.
- R6: Writing 1s to PULSE (0x03) makes those channels active for exactly one cycle. ch_out shows the pulse in the second cycle after the write edge.
- R7: While CTRL bit 1 is 1, output triggers whose bit is set in FMASK (0x05) stay 0. With the bit at 0 they assert normally.
- R8: While CTRL bit 0 is 0, trig_out and ch_out are 0. All programming registers keep their contents.
- R9: CHOUT status (0x08) and TRGOUT status (0x09) are one-hot bitmaps of ch_out and trig_out. Channel 2 reads 0x4 and output trigger 6 reads 0x40. Both return to 0 after the channel is cleared.
- R10: Writing bit 0 = 1 to RST (0x06) resets the block's programming: it clears all attachment masks and held or pulsed channels and opens every gate.
- R11: USE (0x07) has bits 3:0 set for each channel with any attached input or output trigger. Bits 7:4 are the complement, which marks the free channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NUM_IN | Local input triggers |
| trig_out | output | NUM_OUT | Local output triggers, registered |
| ch_in | input | NUM_CH | Channels arriving from the matrix |
| ch_out | output | NUM_CH | Gated channels sent to the matrix, registered |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | DATA_W | Read data, combinational |

## Verification
Directed cases drive one input trigger, then one matrix channel, then a software hold and a pulse into the same attachment. This tells the three channel sources apart and shows that only local sources reach ch_out. The same path is then run with a gate closed, the filter on and off, and the block disabled, so that each blocking mechanism is seen alone. Randomly programmed masks, gates, filters and holds are mixed with random trigger and channel traffic. This traffic exposes wrong OR reduction, swapped mask indices and wrong priority between gating and filtering.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_SET    = 6'h01;
    localparam logic [ADDR_W-1:0] A_CLR    = 6'h02;
    localparam logic [ADDR_W-1:0] A_PULSE  = 6'h03;
    localparam logic [ADDR_W-1:0] A_GATE   = 6'h04;
    localparam logic [ADDR_W-1:0] A_FMASK  = 6'h05;
    localparam logic [ADDR_W-1:0] A_RST    = 6'h06;
    localparam logic [ADDR_W-1:0] A_USE    = 6'h07;
    localparam logic [ADDR_W-1:0] A_CHOUT  = 6'h08;
    localparam logic [ADDR_W-1:0] A_TRGOUT = 6'h09;
    localparam logic [ADDR_W-1:0] A_TRGIN  = 6'h0A;
    localparam logic [ADDR_W-1:0] A_CHIN   = 6'h0B;
    localparam logic [ADDR_W-1:0] A_HOLD   = 6'h0C;
    localparam logic [ADDR_W-1:0] IN_BASE  = 6'h10;
    localparam logic [ADDR_W-1:0] OUT_BASE = 6'h20;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_FILT_BIT = 1;
    localparam int MAX_IDX       = 16;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic                              glob_en,
    output logic                              filt_on,
    output logic [NUM_OUT-1:0]                filt_mask,
    output logic [NUM_CH-1:0]                 gate,
    output logic [NUM_CH-1:0]                 sw_hold,
    output logic [NUM_CH-1:0]                 sw_pulse,
    output logic [NUM_IN-1:0][NUM_CH-1:0]     in_en,
    output logic [NUM_CH-1:0][NUM_OUT-1:0]    out_en,
    output logic [NUM_CH-1:0]                 ch_used
);
    typedef struct packed {
        logic                           en;
        logic                           filt;
        logic [NUM_OUT-1:0]             fmask;
        logic [NUM_CH-1:0]              gate;
        logic [NUM_CH-1:0]              hold;
        logic [NUM_CH-1:0]              pulse;
        logic [NUM_IN-1:0][NUM_CH-1:0]  in_en;
        logic [NUM_CH-1:0][NUM_OUT-1:0] out_en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    r_d.en   = wr_data[CTRL_EN_BIT];
                    r_d.filt = wr_data[CTRL_FILT_BIT];
                end
                A_SET:   r_d.hold  = r_q.hold | wr_data[NUM_CH-1:0];
                A_CLR:   r_d.hold  = r_q.hold & ~wr_data[NUM_CH-1:0];
                A_PULSE: r_d.pulse = wr_data[NUM_CH-1:0];
                A_GATE:  r_d.gate  = wr_data[NUM_CH-1:0];
                A_FMASK: r_d.fmask = wr_data[NUM_OUT-1:0];
                A_RST: begin
                    if (wr_data[0]) begin
                        r_d.in_en  = '0;
                        r_d.out_en = '0;
                        r_d.hold   = '0;
                        r_d.pulse  = '0;
                        r_d.gate   = '1;
                    end
                end
                default: begin
                    for (int i = 0; i < NUM_IN; i++) begin
                        if (wr_addr == IN_BASE + ADDR_W'(i))
                            r_d.in_en[i] = wr_data[NUM_CH-1:0];
                    end
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (wr_addr == OUT_BASE + ADDR_W'(c))
                            r_d.out_en[c] = wr_data[NUM_OUT-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.filt   <= 1'b1;
            r_q.gate   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign glob_en   = r_q.en;
    assign filt_on   = r_q.filt;
    assign filt_mask = r_q.fmask;
    assign gate      = r_q.gate;
    assign sw_hold   = r_q.hold;
    assign sw_pulse  = r_q.pulse;
    assign in_en     = r_q.in_en;
    assign out_en    = r_q.out_en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_use
        logic [NUM_IN-1:0] col;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_col
            assign col[i] = r_q.in_en[i][c];
        end
        assign ch_used[c] = (|col) | (|r_q.out_en[c]);
    end
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic [NUM_IN-1:0]                 trig_in,
    input  logic [NUM_CH-1:0]                 ch_in,
    input  logic [NUM_IN-1:0][NUM_CH-1:0]     in_en,
    input  logic [NUM_CH-1:0][NUM_OUT-1:0]    out_en,
    input  logic [NUM_CH-1:0]                 sw_hold,
    input  logic [NUM_CH-1:0]                 sw_pulse,
    input  logic [NUM_CH-1:0]                 gate,
    input  logic                              glob_en,
    input  logic                              filt_on,
    input  logic [NUM_OUT-1:0]                filt_mask,
    output logic [NUM_CH-1:0]                 ch_out_d,
    output logic [NUM_OUT-1:0]                trig_out_d
);
    logic [NUM_CH-1:0]  ch_local;
    logic [NUM_CH-1:0]  ch_all;
    logic [NUM_OUT-1:0] trig_raw;
    logic [NUM_OUT-1:0] blocked;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_IN-1:0] hits;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_hit
            assign hits[i] = trig_in[i] & in_en[i][c];
        end
        assign ch_local[c] = (|hits) | sw_hold[c] | sw_pulse[c];
    end

    assign ch_all = ch_local | ch_in;

    for (genvar t = 0; t < NUM_OUT; t++) begin : g_out
        logic [NUM_CH-1:0] sel;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
            assign sel[c] = ch_all[c] & out_en[c][t];
        end
        assign trig_raw[t] = |sel;
    end

    assign blocked    = filt_on ? filt_mask : '0;
    assign ch_out_d   = glob_en ? (ch_local & gate) : '0;
    assign trig_out_d = glob_en ? (trig_raw & ~blocked) : '0;
endmodule

// File: rtl/xtrig_outreg.sv
module xtrig_outreg #(
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  ch_out_d,
    input  logic [NUM_OUT-1:0] trig_out_d,
    output logic [NUM_CH-1:0]  ch_out_q,
    output logic [NUM_OUT-1:0] trig_out_q
);
    typedef struct packed {
        logic [NUM_CH-1:0]  ch;
        logic [NUM_OUT-1:0] trig;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.ch   = ch_out_d;
        o_d.trig = trig_out_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ch_out_q   = o_q.ch;
    assign trig_out_q = o_q.trig;
endmodule

// File: rtl/xtrig_chan_if.sv
module xtrig_chan_if
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  trig_in,
    output logic [NUM_OUT-1:0] trig_out,
    input  logic [NUM_CH-1:0]  ch_in,
    output logic [NUM_CH-1:0]  ch_out,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int USE_W = 2 * NUM_CH;

    logic                           glob_en, filt_on;
    logic [NUM_OUT-1:0]             filt_mask;
    logic [NUM_CH-1:0]              gate, sw_hold, sw_pulse, ch_used;
    logic [NUM_IN-1:0][NUM_CH-1:0]  in_en;
    logic [NUM_CH-1:0][NUM_OUT-1:0] out_en;
    logic [NUM_CH-1:0]              ch_out_d;
    logic [NUM_OUT-1:0]             trig_out_d;

    xtrig_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .glob_en(glob_en), .filt_on(filt_on), .filt_mask(filt_mask), .gate(gate),
        .sw_hold(sw_hold), .sw_pulse(sw_pulse), .in_en(in_en), .out_en(out_en),
        .ch_used(ch_used)
    );

    xtrig_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_route (
        .trig_in(trig_in), .ch_in(ch_in), .in_en(in_en), .out_en(out_en),
        .sw_hold(sw_hold), .sw_pulse(sw_pulse), .gate(gate), .glob_en(glob_en),
        .filt_on(filt_on), .filt_mask(filt_mask), .ch_out_d(ch_out_d),
        .trig_out_d(trig_out_d)
    );

    xtrig_outreg #(.NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .ch_out_d(ch_out_d), .trig_out_d(trig_out_d),
        .ch_out_q(ch_out), .trig_out_q(trig_out)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[CTRL_EN_BIT]   = glob_en;
                rd_data[CTRL_FILT_BIT] = filt_on;
            end
            A_GATE:   rd_data = DATA_W'(gate);
            A_FMASK:  rd_data = DATA_W'(filt_mask);
            A_USE:    rd_data = DATA_W'(USE_W'({~ch_used, ch_used}));
            A_CHOUT:  rd_data = DATA_W'(ch_out);
            A_TRGOUT: rd_data = DATA_W'(trig_out);
            A_TRGIN:  rd_data = DATA_W'(trig_in);
            A_CHIN:   rd_data = DATA_W'(ch_in);
            A_HOLD:   rd_data = DATA_W'(sw_hold);
            default: begin
                for (int i = 0; i < NUM_IN; i++) begin
                    if (rd_addr == IN_BASE + ADDR_W'(i)) rd_data = DATA_W'(in_en[i]);
                end
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rd_addr == OUT_BASE + ADDR_W'(c)) rd_data = DATA_W'(out_en[c]);
                end
            end
        endcase
    end
endmodule

// File: rtl/xtrig_chk.sv
module xtrig_chk
    import xtrig_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic               filt_on,
    input logic [NUM_OUT-1:0] filt_mask,
    input logic [NUM_CH-1:0]  gate,
    input logic [NUM_CH-1:0]  ch_used,
    input logic [NUM_OUT-1:0] trig_out,
    input logic [NUM_CH-1:0]  ch_out,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data
);
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (trig_out == '0 && ch_out == '0));

    assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ch_out & ~$past(gate)) == '0));

    assert_filter_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        filt_on |=> ((trig_out & $past(filt_mask)) == '0));

    assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RST && wr_data[0]) |=> (ch_used == '0 && (&gate)));
endmodule

bind xtrig_chan_if xtrig_chk #(.NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .filt_on(filt_on), .filt_mask(filt_mask),
    .gate(gate), .ch_used(ch_used), .trig_out(trig_out), .ch_out(ch_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/xtrig_chan_if_test.sv
module xtrig_chan_if_test;
    localparam int NI = 8;
    localparam int NO = 8;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] trig_in = '0;
    logic [NO-1:0] trig_out;
    logic [NC-1:0] ch_in = '0;
    logic [NC-1:0] ch_out;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [5:0]    rd_addr = '0;
    logic [31:0]   rd_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [NC-1:0] m_in [NI];
    logic [NO-1:0] m_out [NC];
    logic [NC-1:0] m_gate, m_hold;
    logic [NO-1:0] m_fmask;
    logic          m_en, m_filt;

    always #2 clk = ~clk;

    xtrig_chan_if uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
        .ch_in(ch_in), .ch_out(ch_out), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [NC-1:0] f_loc(input logic [NI-1:0] t);
        logic [NC-1:0] l = m_hold;
        for (int i = 0; i < NI; i++) if (t[i]) l |= m_in[i];
        return l;
    endfunction

    function automatic logic [NC-1:0] f_ch(input logic [NI-1:0] t);
        return m_en ? (f_loc(t) & m_gate) : '0;
    endfunction

    function automatic logic [NO-1:0] f_trig(input logic [NI-1:0] t, input logic [NC-1:0] ci);
        logic [NC-1:0] all = f_loc(t) | ci;
        logic [NO-1:0] o = '0;
        for (int c = 0; c < NC; c++) if (all[c]) o |= m_out[c];
        if (m_filt) o &= ~m_fmask;
        return m_en ? o : '0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 trig_out", 32'(trig_out), 32'h0);
        chk("R1 ch_out", 32'(ch_out), 32'h0);
        rd(6'h00, v); chk("R1 ctrl", v, 32'h2);
        rd(6'h04, v); chk("R1 gate", v, 32'hF);
        rd(6'h07, v); chk("R1 use", v, 32'hF0);
        rd(6'h11, v); chk("R1 in mask", v, 32'h0);
        step();
        wr(6'h00, 32'h3);
        trig_in = '1; ch_in = '1;
        step();
        chk("R1 unprogrammed trig_out", 32'(trig_out), 32'h0);
        chk("R1 unprogrammed ch_out", 32'(ch_out), 32'h0);
        trig_in = '0; ch_in = '0;

        // R2 input trigger 1 -> channel 2 -> output trigger 6
        wr(6'h11, 32'h4);
        wr(6'h22, 32'h40);
        trig_in = 8'h02;
        step();
        chk("R2 ch_out", 32'(ch_out), 32'h4);
        chk("R2 trig_out", 32'(trig_out), 32'h40);
        rd(6'h08, v); chk("R9 chout status", v, 32'h4);
        rd(6'h09, v); chk("R9 trgout status", v, 32'h40);
        trig_in = '0;
        step();
        chk("R2 idle trig_out", 32'(trig_out), 32'h0);

        // R11 channel view
        rd(6'h07, v); chk("R11 use/free", v, 32'hB4);
        step();

        // R5 / R9 software set and clear
        wr(6'h01, 32'h4);
        step();
        chk("R5 set ch_out", 32'(ch_out), 32'h4);
        rd(6'h09, v); chk("R9 set trgout status", v, 32'h40);
        step();
        wr(6'h02, 32'h4);
        step();
        rd(6'h08, v); chk("R9 cleared chout", v, 32'h0);
        rd(6'h09, v); chk("R9 cleared trgout", v, 32'h0);
        chk("R5 clear ch_out", 32'(ch_out), 32'h0);
        step();

        // R3 matrix channel drives local outputs only
        ch_in = 4'h4;
        step();
        chk("R3 trig_out", 32'(trig_out), 32'h40);
        chk("R3 ch_out", 32'(ch_out), 32'h0);
        ch_in = '0;

        // R4 gate closed on channel 2
        wr(6'h04, 32'hB);
        trig_in = 8'h02;
        step();
        chk("R4 ch_out gated", 32'(ch_out), 32'h0);
        chk("R4 trig_out kept", 32'(trig_out), 32'h40);
        trig_in = '0;
        wr(6'h04, 32'hF);
        step();

        // R6 pulse
        wr(6'h03, 32'h4);
        chk("R6 pulse early", 32'(ch_out), 32'h0);
        step();
        chk("R6 pulse ch_out", 32'(ch_out), 32'h4);
        chk("R6 pulse trig_out", 32'(trig_out), 32'h40);
        step();
        chk("R6 pulse end", 32'(ch_out), 32'h0);

        // R7 filter
        wr(6'h05, 32'h40);
        trig_in = 8'h02;
        step();
        chk("R7 filtered", 32'(trig_out), 32'h0);
        chk("R7 channel unaffected", 32'(ch_out), 32'h4);
        wr(6'h00, 32'h1);
        step();
        chk("R7 filter off", 32'(trig_out), 32'h40);
        wr(6'h00, 32'h3);
        wr(6'h05, 32'h0);

        // R8 global disable
        wr(6'h00, 32'h2);
        step();
        chk("R8 trig_out off", 32'(trig_out), 32'h0);
        chk("R8 ch_out off", 32'(ch_out), 32'h0);
        rd(6'h11, v); chk("R8 mask retained", v, 32'h4);
        step();
        wr(6'h00, 32'h3);
        trig_in = '0;

        // R10 reset command
        wr(6'h04, 32'h5);
        wr(6'h01, 32'h8);
        wr(6'h06, 32'h1);
        rd(6'h07, v); chk("R10 use cleared", v, 32'hF0);
        rd(6'h04, v); chk("R10 gate reopened", v, 32'hF);
        rd(6'h0C, v); chk("R10 hold cleared", v, 32'h0);
        step();
        trig_in = 8'h02; ch_in = 4'hF;
        step();
        chk("R10 no route trig", 32'(trig_out), 32'h0);
        chk("R10 no route ch", 32'(ch_out), 32'h0);
        trig_in = '0; ch_in = '0;

        // Random programming and traffic (R2 R3 R4 R5 R7 R8)
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < NI; i++) begin
                m_in[i] = NC'($urandom);
                if ($urandom % 3 == 0) m_in[i] = '0;
                wr(6'h10 + 6'(i), 32'(m_in[i]));
            end
            for (int c = 0; c < NC; c++) begin
                m_out[c] = NO'($urandom);
                wr(6'h20 + 6'(c), 32'(m_out[c]));
            end
            m_gate = NC'($urandom);  wr(6'h04, 32'(m_gate));
            m_fmask = NO'($urandom); wr(6'h05, 32'(m_fmask));
            m_filt = 1'($urandom);
            m_en = ($urandom % 5) != 0;
            wr(6'h00, {30'd0, m_filt, m_en});
            wr(6'h02, 32'hF);
            m_hold = ($urandom % 2) ? NC'($urandom) & NC'($urandom) : '0;
            wr(6'h01, 32'(m_hold));
            for (int k = 0; k < 25; k++) begin
                logic [NI-1:0] t;
                logic [NC-1:0] ci;
                t = NI'($urandom) & NI'($urandom);
                ci = NC'($urandom) & NC'($urandom);
                trig_in = t; ch_in = ci;
                step();
                chk("R2 random ch_out", 32'(ch_out), 32'(f_ch(t)));
                chk("R3 random trig_out", 32'(trig_out), 32'(f_trig(t, ci)));
            end
            trig_in = '0; ch_in = '0;
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule